// File: doc/BRIEF.md
# SPI Controller Interrupt Status and Mask Unit

This unit collects the interrupt sources of an SPI controller and turns them into one interrupt line. It receives the live transmit FIFO fill level, a receive-not-empty level, a transmit-full level and a one-cycle mode-fault event from the FIFOs and the serial engine. It keeps a 7-bit status register and a 7-bit mask. The output interrupt is the OR of all status bits that are also masked in, and it is taken from a flop.

Software reaches the unit through a simple register port. There is one write strobe with an address and data, and a separate combinational read address with read data. The mask is never written directly. Ones written to an enable register set mask bits, and ones written to a disable register clear them. A read-only view returns the current mask. A combined update register carries set bits and clear bits in one write; when both name the same bit, the clear wins. A programmable watermark is compared with the transmit fill level. While the level is strictly below the watermark, a "transmit below watermark" source is raised.

The unit has no state machine. Status, mask, watermark and the interrupt flop are plain registers that update on every clock.

Top module: `spi_irq_unit`

## Requirements
- R1: While reset is asserted, status reads 0x00, mask reads 0x00, the watermark reads 1 and `irq` is 0.
- R2: Status, enable, disable, mask and combined-update registers share one 7-bit layout: bit 1 mode fault, bit 2 transmit below watermark, bit 3 transmit full, bit 4 receive not empty. Status bits 0, 5 and 6 always read 0.
- R3: Register addresses are 0 status (read, write-one-to-clear), 1 enable (write only), 2 disable (write only), 3 mask view (read only), 4 watermark (read/write, low 8 bits), 5 combined update (set bits in data[6:0], clear bits in data[14:8]). Writing ones to address 1 sets those mask bits and leaves other bits alone. Reading addresses 1 and 2 returns 0.
- R4: Writing ones to address 2 clears those mask bits and leaves other bits alone.
- R5: In a write to address 5, a bit named in both the set field and the clear field ends up cleared. Bits named only in the set field end up set.
- R6: A mode-fault event sets status bit 1 on the next clock. The bit stays set until a one is written to bit 1 of address 0. If a new event arrives in the same cycle as that clear, the bit stays set.
- R7: Status bits 3 and 4 follow the transmit-full and receive-not-empty inputs one clock later. A write-one-to-clear does not remove them while their condition holds.
- R8: Status bit 2 is 1 exactly when, one clock earlier, the transmit level was strictly less than the watermark. The watermark is read back as written.
- R9: `irq` equals the OR of (status AND mask), delayed by one clock.
- R10: Writes to address 3 leave the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W (16) | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W (16) | Combinational read data |
| tx_level | input | LVL_W (8) | Live transmit FIFO fill level |
| rx_nonempty | input | 1 | Receive FIFO holds data |
| tx_full | input | 1 | Transmit FIFO is full |
| mode_fault_evt | input | 1 | One-cycle mode-fault event |
| irq | output | 1 | Registered interrupt request |

## Verification
A vector table drives combinations of fill level, receive and full levels, and mask patterns. Each combination separates one source from the others. An interrupt is expected only when a live source is masked in, so wrong mask gating or a wrong bit position both show up. Directed sequences cover the following:
- the accumulate and clear behaviour of the set and clear registers, and the clear-wins collision;
- a write to the read-only mask view;
- a mode fault that persists until cleared, and a clear that collides with a new event;
- level bits that survive a clear;
- watermark levels just below, at, and far from the threshold;
- the one-cycle lag of `irq` behind the status register.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int IRQ_W   = 7;
    localparam int ADDR_W  = 3;
    localparam int CLR_LSB = 8;

    localparam int BIT_MODF = 1;
    localparam int BIT_TXLO = 2;
    localparam int BIT_TXF  = 3;
    localparam int BIT_RXNE = 4;

    // Sources that latch until written with a one; all others follow their condition.
    localparam logic [IRQ_W-1:0] STICKY_SET = IRQ_W'(1 << BIT_MODF);

    typedef enum logic [ADDR_W-1:0] {
        REG_STAT  = 3'd0,
        REG_ENA   = 3'd1,
        REG_DIS   = 3'd2,
        REG_MASKV = 3'd3,
        REG_WMARK = 3'd4,
        REG_ENDIS = 3'd5
    } reg_sel_e;

endpackage

// File: rtl/spi_irq_mask.sv
module spi_irq_mask
    import spi_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] set_v,
    input  logic [IRQ_W-1:0] clr_v,
    output logic [IRQ_W-1:0] mask_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= (mask_q | set_v) & ~clr_v;
        end
    end

    // R4 / R5: any bit named for clearing is gone the next cycle
    a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_v) |=> ((mask_q & $past(clr_v)) == '0));

    // R3: bits named only for setting are present the next cycle
    a_r3_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_v & ~clr_v)) |=> ((mask_q & $past(set_v & ~clr_v)) == $past(set_v & ~clr_v)));

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] src_v,
    input  logic [IRQ_W-1:0] w1c_v,
    output logic [IRQ_W-1:0] stat_q
);

    for (genvar b = 0; b < IRQ_W; b++) begin : g_bit
        if (STICKY_SET[b]) begin : g_sticky
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stat_q[b] <= 1'b0;
                else        stat_q[b] <= src_v[b] | (stat_q[b] & ~w1c_v[b]);
            end
        end else begin : g_level
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stat_q[b] <= 1'b0;
                else        stat_q[b] <= src_v[b];
            end
        end
    end

    // R6: event latches on the next clock
    a_r6_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
        src_v[BIT_MODF] |=> stat_q[BIT_MODF]);

    // R6: latched fault survives when not cleared
    a_r6_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[BIT_MODF] && !w1c_v[BIT_MODF]) |=> stat_q[BIT_MODF]);

    // R7: receive level bit tracks its source one clock later
    a_r7_rx_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stat_q[BIT_RXNE] == $past(src_v[BIT_RXNE])));

endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
    import spi_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int DATA_W     = 16,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic              rx_nonempty,
    input  logic              tx_full,
    input  logic              mode_fault_evt,
    output logic              irq
);

    localparam int PAD_W = DATA_W - IRQ_W;
    localparam int WPAD  = DATA_W - LVL_W;

    logic [IRQ_W-1:0] set_v, clr_v, w1c_v, src_v;
    logic [IRQ_W-1:0] stat_q, mask_q;
    logic [LVL_W-1:0] wmark_q;
    logic             tx_below;
    logic             irq_q;
    reg_sel_e         wsel, rsel;

    assign wsel = reg_sel_e'(wr_addr);
    assign rsel = reg_sel_e'(rd_addr);

    always_comb begin
        set_v = '0;
        clr_v = '0;
        w1c_v = '0;
        if (wr_en) begin
            case (wsel)
                REG_STAT:  w1c_v = wr_data[IRQ_W-1:0];
                REG_ENA:   set_v = wr_data[IRQ_W-1:0];
                REG_DIS:   clr_v = wr_data[IRQ_W-1:0];
                REG_ENDIS: begin
                    set_v = wr_data[IRQ_W-1:0];
                    clr_v = wr_data[CLR_LSB+IRQ_W-1:CLR_LSB];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           wmark_q <= LVL_W'(1);
        else if (wr_en && wsel == REG_WMARK)  wmark_q <= wr_data[LVL_W-1:0];
    end

    assign tx_below = (tx_level < wmark_q);

    always_comb begin
        src_v           = '0;
        src_v[BIT_MODF] = mode_fault_evt;
        src_v[BIT_TXLO] = tx_below;
        src_v[BIT_TXF]  = tx_full;
        src_v[BIT_RXNE] = rx_nonempty;
    end

    spi_irq_status i_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_v  (src_v),
        .w1c_v  (w1c_v),
        .stat_q (stat_q)
    );

    spi_irq_mask i_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_v  (set_v),
        .clr_v  (clr_v),
        .mask_q (mask_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(stat_q & mask_q);
    end

    assign irq = irq_q;

    always_comb begin
        case (rsel)
            REG_STAT:  rd_data = {{PAD_W{1'b0}}, stat_q};
            REG_MASKV: rd_data = {{PAD_W{1'b0}}, mask_q};
            REG_WMARK: rd_data = {{WPAD{1'b0}}, wmark_q};
            default:   rd_data = '0;
        endcase
    end

    // R9: interrupt lags the masked status by one clock
    a_r9_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == $past(|(stat_q & mask_q))));

    // R8: watermark status reflects the previous cycle's comparison
    a_r8_watermark: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stat_q[BIT_TXLO] == ($past(tx_level) < $past(wmark_q))));

    // R10: the mask view address never changes the mask
    a_r10_view_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wsel == REG_MASKV) |=> $stable(mask_q));

endmodule

// File: tb/test_spi_irq_unit.sv
module test_spi_irq_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 8;

    // {level[7:0], rx, full, enable[6:0], expect_status[6:0], expect_irq}
    localparam logic [24:0] VECS [NVEC] = '{
        {8'd0,   1'b0, 1'b0, 7'h04, 7'h04, 1'b1},
        {8'd5,   1'b0, 1'b0, 7'h04, 7'h00, 1'b0},
        {8'd5,   1'b1, 1'b0, 7'h10, 7'h10, 1'b1},
        {8'd5,   1'b1, 1'b0, 7'h08, 7'h10, 1'b0},
        {8'd128, 1'b1, 1'b1, 7'h08, 7'h18, 1'b1},
        {8'd0,   1'b0, 1'b0, 7'h00, 7'h04, 1'b0},
        {8'd1,   1'b0, 1'b1, 7'h1E, 7'h08, 1'b1},
        {8'd1,   1'b0, 1'b0, 7'h7F, 7'h00, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [7:0]  tx_level = '0;
    logic        rx_nonempty = 1'b0;
    logic        tx_full = 1'b0;
    logic        mode_fault_evt = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_irq_unit i_spi_irq_unit (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .rd_addr        (rd_addr),
        .rd_data        (rd_data),
        .tx_level       (tx_level),
        .rx_nonempty    (rx_nonempty),
        .tx_full        (tx_full),
        .mode_fault_evt (mode_fault_evt),
        .irq            (irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the write took effect
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        // R1: reset state
        rd(3'd0, v); chk("R1 status in reset", v, 0);
        rd(3'd3, v); chk("R1 mask in reset", v, 0);
        rd(3'd4, v); chk("R1 watermark in reset", v, 1);
        chk("R1 irq in reset", int'(irq), 0);
        rst_n = 1'b1;
        tx_level = 8'd50;
        @(negedge clk);

        // table walk: R2 bit positions, R7, R8, R9
        for (int i = 0; i < NVEC; i++) begin
            wr(3'd2, 16'h007F);
            wr(3'd1, {9'd0, VECS[i][14:8]});
            tx_level    = VECS[i][24:17];
            rx_nonempty = VECS[i][16];
            tx_full     = VECS[i][15];
            repeat (2) @(negedge clk);
            rd(3'd0, v); chk($sformatf("R2 vector %0d status", i), v, int'(VECS[i][7:1]));
            chk($sformatf("R9 vector %0d irq", i), int'(irq), int'(VECS[i][0]));
        end

        // R3 / R4 / R10 / R5 mask operations
        tx_level = 8'd50; rx_nonempty = 1'b0; tx_full = 1'b0;
        wr(3'd2, 16'h007F);
        wr(3'd1, 16'h0012);
        rd(3'd3, v); chk("R3 enable sets", v, 'h12);
        wr(3'd1, 16'h0004);
        rd(3'd3, v); chk("R3 enable accumulates", v, 'h16);
        rd(3'd1, v); chk("R3 enable reads zero", v, 0);
        rd(3'd2, v); chk("R3 disable reads zero", v, 0);
        wr(3'd2, 16'h0002);
        rd(3'd3, v); chk("R4 disable clears one bit", v, 'h14);
        wr(3'd3, 16'h007F);
        rd(3'd3, v); chk("R10 mask view write ignored", v, 'h14);
        wr(3'd5, 16'h080A);
        rd(3'd3, v); chk("R5 clear wins on collision", v, 'h16);

        // R9 timing and R6 sticky fault
        wr(3'd2, 16'h007F);
        wr(3'd1, 16'h0002);
        @(negedge clk);
        chk("R9 irq idle", int'(irq), 0);
        mode_fault_evt = 1'b1;
        @(negedge clk);
        mode_fault_evt = 1'b0;
        rd(3'd0, v); chk("R6 fault latched", v & 'h02, 'h02);
        chk("R9 irq one cycle later", int'(irq), 0);
        @(negedge clk);
        chk("R9 irq asserted", int'(irq), 1);
        repeat (3) @(negedge clk);
        rd(3'd0, v); chk("R6 fault persists", v & 'h02, 'h02);
        wr(3'd0, 16'h0002);
        rd(3'd0, v); chk("R6 fault cleared", v & 'h02, 0);
        @(negedge clk);
        chk("R9 irq drops after clear", int'(irq), 0);
        mode_fault_evt = 1'b1;
        wr(3'd0, 16'h0002);
        mode_fault_evt = 1'b0;
        rd(3'd0, v); chk("R6 event beats clear", v & 'h02, 'h02);
        wr(3'd0, 16'h0002);

        // R7 level bits ignore clear
        rx_nonempty = 1'b1; tx_full = 1'b1;
        @(negedge clk);
        wr(3'd0, 16'h0018);
        rd(3'd0, v); chk("R7 level bits survive clear", v & 'h18, 'h18);
        // R2 reserved bits with every source active
        tx_level = 8'd0;
        mode_fault_evt = 1'b1;
        @(negedge clk);
        mode_fault_evt = 1'b0;
        rd(3'd0, v); chk("R2 reserved bits zero", v & 'h61, 0);
        chk("R2 all sources present", v, 'h1E);
        rx_nonempty = 1'b0; tx_full = 1'b0;
        wr(3'd0, 16'h0002);

        // R8 watermark boundaries
        wr(3'd4, 16'd10);
        rd(3'd4, v); chk("R8 watermark readback", v, 10);
        tx_level = 8'd9;
        @(negedge clk);
        rd(3'd0, v); chk("R8 level below threshold", v & 'h04, 'h04);
        tx_level = 8'd10;
        @(negedge clk);
        rd(3'd0, v); chk("R8 level equal to threshold", v & 'h04, 0);
        wr(3'd4, 16'd0);
        tx_level = 8'd0;
        @(negedge clk);
        rd(3'd0, v); chk("R8 zero watermark never fires", v & 'h04, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule